// File: doc/BRIEF.md
# External Memory Access Timing Sequencer

This block produces the cycle-by-cycle timing of accesses to one region of an external parallel memory. An internal client issues single or multi-word read and write requests on a valid/ready port. The sequencer then drives the device strobes and times each word against programmable counts: access time, cycle time and word spacing within a page or burst. It marks the cycle in which read data is sampled and the cycle in which a synchronously clocked device takes write data. A WAIT input from the device stretches these phases.

Timing fields come from static configuration inputs. A mode bit selects synchronous or asynchronous device behaviour, and a scaling bit doubles the word-spacing field. Between accesses the data bus is not left floating: the last word that was read or written stays driven until the next access begins. An access count or word-spacing count of zero is treated as one. A request length of zero is treated as one word.

In the requirements below, cycle 1 is the first clock cycle after the edge at which a request is accepted. The access count runs down once per cycle and skips every cycle that WAIT stalls.

Top module: `xmem_timing_seq`

## Requirements
- R1: `cfg_err` is high whenever the read cycle count is less than or equal to the read access count. A read request made while it is high gets `rsp_done` and `rsp_err` in cycle 1, and no strobe is driven.
- R2: A single read asserts `rd_cap` in cycle A (A = read access count) when there is no stall. `rsp_done` follows in the next cycle, and `rsp_rdata` equals `mem_dq_in` as sampled at the end of the capture cycle.
- R3: In a multi-word read, consecutive `rd_cap` pulses are spaced by the effective word spacing. This is the 4-bit spacing field times 1, or times 2 when `cfg_gran_x2` is 1. Each word gets its own `rsp_done` pulse and data.
- R4: `mem_wait` is registered once. Each cycle in which the registered value is high during an access phase freezes the counters and delays the next capture by one cycle. This applies to the first word and to later words, in reads and in synchronous writes.
- R5: A synchronous write (`cfg_sync`=1) drives `mem_we_n` low from cycle 1 and pulses `mem_cap` in cycle A (A = write access count). Later burst words follow at the effective word spacing. Each later word's data is taken from `req_wdata` at the previous capture edge. `mem_cap` and `mem_we_n` never go low together with `mem_oe_n`.
- R6: An asynchronous write (`cfg_sync`=0) holds `mem_we_n` low for A unstalled cycles and never pulses `mem_cap`. WAIT is ignored while more than 2 counts remain and is obeyed in the last 2.
- R7: An asynchronous write request with a length above one gets `rsp_done` and `rsp_err` in cycle 1 and performs no access.
- R8: `req_ready` is low from cycle 1 until the unstalled cycle count reaches the cycle time (read or write count) and the last word has been captured. It returns high in the cycle after that.
- R9: When an access ends, `mem_dq_oe` goes high and `mem_dq_out` holds the last word read or written until the next access. A read access turns `mem_dq_oe` off from cycle 1. A write keeps driving throughout.
- R10: In reset, `req_ready` is 1, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe`, `mem_cap`, `rd_cap`, `rsp_done` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | synchronous reset, active low |
| cfg_sync | input | 1 | 1: synchronous device, 0: asynchronous |
| cfg_gran_x2 | input | 1 | doubles the word-spacing field |
| cfg_rd_acc | input | 5 | read access count |
| cfg_rd_cyc | input | 5 | read cycle count |
| cfg_wr_acc | input | 5 | write access count (asynchronous: WAIT window) |
| cfg_wr_cyc | input | 5 | write cycle count |
| cfg_page_acc | input | 4 | word spacing within a page or burst |
| cfg_err | output | 1 | illegal read timing flag |
| req_valid | input | 1 | request valid |
| req_write | input | 1 | 1 write, 0 read |
| req_len | input | 4 | words in the request |
| req_wdata | input | 16 | write data for the next word |
| req_ready | output | 1 | idle, may accept a request |
| rsp_done | output | 1 | one word finished, or request rejected |
| rsp_err | output | 1 | request rejected |
| rsp_rdata | output | 16 | captured read word |
| mem_wait | input | 1 | device wait, active high |
| mem_dq_in | input | 16 | data bus from device |
| mem_dq_out | output | 16 | data bus to device |
| mem_dq_oe | output | 1 | data bus drive enable |
| mem_oe_n | output | 1 | device output enable, active low |
| mem_we_n | output | 1 | device write enable, active low |
| mem_cap | output | 1 | device capture edge of a synchronous write |
| rd_cap | output | 1 | read data capture strobe |

## Verification
The bench targets the cycle in which each capture lands. A one-cycle error in the count reload or in the handling of the WAIT register would show up as a capture strobe one cycle early or late, or as read data taken from the wrong cycle of a changing bus. WAIT is placed both inside and outside the asynchronous ignore window. A design that applied the window to every mode, or to none, would stretch or fail to stretch the write. Multi-word reads and writes check the spacing with the doubling bit set and clear, and that each new write word is taken at its own edge. The bus is checked across access boundaries. A design that failed to release the bus for a read, or failed to hold it after a write, would show the wrong enable or a changed data value.

// File: rtl/xts_pkg.sv
package xts_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACC  = 2'd1,
        S_PAGE = 2'd2,
        S_CYC  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/xts_cfg.sv
// Turns raw timing fields into the counts the sequencer loads.
module xts_cfg #(
    parameter int TW = 5,
    parameter int PW = 4
) (
    input  logic          gran_x2,
    input  logic          wr_sel,
    input  logic [TW-1:0] rd_acc,
    input  logic [TW-1:0] rd_cyc,
    input  logic [TW-1:0] wr_acc,
    input  logic [TW-1:0] wr_cyc,
    input  logic [PW-1:0] page,
    output logic [TW-1:0] acc_eff,
    output logic [TW-1:0] cyc_eff,
    output logic [TW-1:0] page_eff,
    output logic          rd_bad
);
    logic [TW-1:0] acc_raw;
    logic [PW:0]   page_scaled;

    assign acc_raw     = wr_sel ? wr_acc : rd_acc;
    assign acc_eff     = (acc_raw == '0) ? TW'(1) : acc_raw;
    assign cyc_eff     = wr_sel ? wr_cyc : rd_cyc;
    assign page_scaled = gran_x2 ? {page, 1'b0} : {1'b0, page};
    assign page_eff    = (page_scaled == '0) ? TW'(1) : TW'(page_scaled);
    // The last read word is sampled before the cycle ends only if cycle > access.
    assign rd_bad      = (rd_cyc <= rd_acc);
endmodule

// File: rtl/xts_stall.sv
// Decides whether a registered WAIT freezes the current access phase.
module xts_stall #(
    parameter int TW  = 5,
    parameter int WIN = 2
) (
    input  logic          wait_q,
    input  logic          active,
    input  logic          async_wr,
    input  logic [TW-1:0] cnt,
    output logic          stall
);
    logic ignored;

    // An asynchronous write only listens to WAIT in its last WIN counts.
    assign ignored = async_wr && (cnt > TW'(WIN));
    assign stall   = active && wait_q && !ignored;
endmodule

// File: rtl/xmem_timing_seq.sv
module xmem_timing_seq #(
    parameter int DW  = 16,
    parameter int LW  = 4,
    parameter int TW  = 5,
    parameter int PW  = 4,
    parameter int CW  = 8,
    parameter int WIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sync,
    input  logic          cfg_gran_x2,
    input  logic [TW-1:0] cfg_rd_acc,
    input  logic [TW-1:0] cfg_rd_cyc,
    input  logic [TW-1:0] cfg_wr_acc,
    input  logic [TW-1:0] cfg_wr_cyc,
    input  logic [PW-1:0] cfg_page_acc,
    output logic          cfg_err,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [LW-1:0] req_len,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    input  logic          mem_wait,
    input  logic [DW-1:0] mem_dq_in,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_cap,
    output logic          rd_cap
);
    import xts_pkg::*;

    localparam logic [CW-1:0] TOT_MAX = {CW{1'b1}};

    typedef struct packed {
        seq_st_e       st;
        logic          wr;
        logic          sync;
        logic [TW-1:0] cnt;
        logic [CW-1:0] tot;
        logic [LW-1:0] left;
        logic [DW-1:0] data;
        logic          keep;
        logic          done;
        logic          err;
        logic          wait_s;
    } seq_t;

    seq_t seq_q, seq_d;

    logic          wr_sel;
    logic [TW-1:0] acc_eff, cyc_eff, page_eff;
    logic          rd_bad;
    logic          active, stall, cap_now;
    logic [LW-1:0] len_eff;
    logic [CW-1:0] tot_inc;
    logic          cyc_met;

    assign wr_sel = (seq_q.st == S_IDLE) ? req_write : seq_q.wr;

    xts_cfg #(.TW(TW), .PW(PW)) u_cfg (
        .gran_x2  (cfg_gran_x2),
        .wr_sel   (wr_sel),
        .rd_acc   (cfg_rd_acc),
        .rd_cyc   (cfg_rd_cyc),
        .wr_acc   (cfg_wr_acc),
        .wr_cyc   (cfg_wr_cyc),
        .page     (cfg_page_acc),
        .acc_eff  (acc_eff),
        .cyc_eff  (cyc_eff),
        .page_eff (page_eff),
        .rd_bad   (rd_bad)
    );

    assign active = (seq_q.st == S_ACC) || (seq_q.st == S_PAGE);

    xts_stall #(.TW(TW), .WIN(WIN)) u_stall (
        .wait_q   (seq_q.wait_s),
        .active   (active),
        .async_wr (seq_q.wr && !seq_q.sync),
        .cnt      (seq_q.cnt),
        .stall    (stall)
    );

    assign cap_now = active && !stall && (seq_q.cnt == TW'(1));
    assign len_eff = (req_len == '0) ? LW'(1) : req_len;
    assign tot_inc = (seq_q.tot == TOT_MAX) ? seq_q.tot : seq_q.tot + 1'b1;
    assign cyc_met = (seq_q.tot >= CW'(cyc_eff));

    always_comb begin
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        seq_d.err    = 1'b0;
        seq_d.wait_s = mem_wait;
        unique case (seq_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if ((!req_write && rd_bad) ||
                        (req_write && !cfg_sync && (len_eff > LW'(1)))) begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end else begin
                        seq_d.st   = S_ACC;
                        seq_d.wr   = req_write;
                        seq_d.sync = cfg_sync;
                        seq_d.cnt  = acc_eff;
                        seq_d.tot  = CW'(1);
                        seq_d.left = len_eff;
                        if (req_write) begin
                            seq_d.data = req_wdata;
                        end
                    end
                end
            end
            S_ACC, S_PAGE: begin
                if (!stall) begin
                    seq_d.tot = tot_inc;
                    if (cap_now) begin
                        seq_d.done = 1'b1;
                        if (!seq_q.wr) begin
                            seq_d.data = mem_dq_in;
                        end
                        if (seq_q.left > LW'(1)) begin
                            seq_d.left = seq_q.left - 1'b1;
                            seq_d.cnt  = page_eff;
                            seq_d.st   = S_PAGE;
                            if (seq_q.wr) begin
                                seq_d.data = req_wdata;
                            end
                        end else if (cyc_met) begin
                            seq_d.st   = S_IDLE;
                            seq_d.keep = 1'b1;
                        end else begin
                            seq_d.st = S_CYC;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            S_CYC: begin
                seq_d.tot = tot_inc;
                if (cyc_met) begin
                    seq_d.st   = S_IDLE;
                    seq_d.keep = 1'b1;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, wr: 1'b0, sync: 1'b0, cnt: '0, tot: '0,
                       left: '0, data: '0, keep: 1'b0, done: 1'b0,
                       err: 1'b0, wait_s: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cfg_err    = rd_bad;
    assign req_ready  = (seq_q.st == S_IDLE);
    assign rsp_done   = seq_q.done;
    assign rsp_err    = seq_q.err;
    assign rsp_rdata  = seq_q.data;
    assign mem_dq_out = seq_q.data;
    assign mem_dq_oe  = (seq_q.st == S_IDLE) ? seq_q.keep : seq_q.wr;
    assign mem_oe_n   = !(active && !seq_q.wr);
    assign mem_we_n   = !(active && seq_q.wr);
    assign rd_cap     = cap_now && !seq_q.wr;
    assign mem_cap    = cap_now && seq_q.wr && seq_q.sync;
endmodule

// File: rtl/xts_checker.sv
module xts_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_err,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic [DW-1:0] mem_dq_in,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_cap,
    input logic          rd_cap
);
    a_r2_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cap |=> (rsp_done && !rsp_err && rsp_rdata == $past(mem_dq_in)));

    a_r9_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    a_r5_capture_inside_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cap |-> !mem_we_n);

    a_r8_busy_while_strobing: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n || rd_cap) |-> !req_ready);

    a_r1_bad_read_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && cfg_err) |=> (rsp_done && rsp_err));

    a_r9_idle_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready) && !$past(req_valid)) |-> $stable(mem_dq_out));
endmodule

bind xmem_timing_seq xts_checker #(.DW(DW)) u_xts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_err    (cfg_err),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .mem_dq_in  (mem_dq_in),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_cap    (mem_cap),
    .rd_cap     (rd_cap)
);

// File: tb/xmem_timing_seq_test.sv
module xmem_timing_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sync = 1'b0, cfg_gran_x2 = 1'b0;
    logic [4:0]  cfg_rd_acc = 5'd3, cfg_rd_cyc = 5'd5, cfg_wr_acc = 5'd4, cfg_wr_cyc = 5'd6;
    logic [3:0]  cfg_page_acc = 4'd1;
    logic        cfg_err;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_len = 4'd1;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        mem_wait = 1'b0;
    logic [15:0] mem_dq_in = '0;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe, mem_oe_n, mem_we_n, mem_cap, rd_cap;

    int checks = 0;
    int errors = 0;

    logic [31:0] cap_m, mcap_m, done_m, err_m, we_m, oe_m, dqoe_m, rdy_m;
    logic [15:0] dqo [0:31];
    logic [15:0] rdv [0:31];

    always #10 clk = ~clk;

    xmem_timing_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_gran_x2(cfg_gran_x2),
        .cfg_rd_acc(cfg_rd_acc), .cfg_rd_cyc(cfg_rd_cyc), .cfg_wr_acc(cfg_wr_acc),
        .cfg_wr_cyc(cfg_wr_cyc), .cfg_page_acc(cfg_page_acc), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_write(req_write), .req_len(req_len),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_wait(mem_wait),
        .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_cap(mem_cap), .rd_cap(rd_cap)
    );

    function automatic logic [31:0] span(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] b(input int k);
        return 32'd1 << k;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Cycle k = k-th cycle after the accept edge. wmask[k] = registered WAIT in cycle k.
    task automatic run(input logic wr, input logic [3:0] len, input logic [15:0] w1,
                       input logic [15:0] w2, input logic [31:0] wmask, input int ncyc);
        cap_m = '0; mcap_m = '0; done_m = '0; err_m = '0;
        we_m = '0; oe_m = '0; dqoe_m = '0; rdy_m = '0;
        for (int i = 0; i < 32; i++) begin dqo[i] = '0; rdv[i] = '0; end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_len = len; req_wdata = w1;
        mem_wait = wmask[1]; mem_dq_in = 16'h1000;
        @(posedge clk);
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cap_m[k] = rd_cap; mcap_m[k] = mem_cap; done_m[k] = rsp_done;
            err_m[k] = rsp_err; we_m[k] = !mem_we_n; oe_m[k] = !mem_oe_n;
            dqoe_m[k] = mem_dq_oe; rdy_m[k] = req_ready; dqo[k] = mem_dq_out;
            if (rsp_done) rdv[k] = rsp_rdata;
            mem_dq_in = 16'h1000 + 16'(k);
            mem_wait  = (k < 31) ? wmask[k+1] : 1'b0;
            if (k == 1) req_wdata = w2;
        end
        mem_wait = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10", "ready", {31'd0, req_ready}, 32'd1);
        chk("R10", "strobes we/oe", {30'd0, mem_we_n, mem_oe_n}, 32'd3);
        chk("R10", "dq_oe/cap/rdcap/done/err",
            {27'd0, mem_dq_oe, mem_cap, rd_cap, rsp_done, rsp_err}, 32'd0);
    endtask

    task automatic t_sync_write;
        cfg_sync = 1'b1; cfg_wr_acc = 5'd4; cfg_wr_cyc = 5'd6;
        run(1'b1, 4'd1, 16'hBEEF, 16'h1234, 32'd0, 10);
        chk("R5", "sync write capture edge", mcap_m, b(4));
        chk("R5", "write strobe", we_m, span(1, 4));
        chk("R8", "ready after write", rdy_m, span(7, 10));
        chk("R9", "bus driven in and after write", dqoe_m, span(1, 10));
        chk("R9", "held write word", {16'd0, dqo[10]}, 32'h0000BEEF);
    endtask

    task automatic t_sync_wait;
        run(1'b1, 4'd1, 16'h0F0F, 16'h0F0F, b(2), 9);
        chk("R4", "sync write capture with wait", mcap_m, b(5));
        chk("R4", "ready with wait", rdy_m, span(8, 9));
    endtask

    task automatic t_sync_burst;
        cfg_wr_acc = 5'd2; cfg_wr_cyc = 5'd3; cfg_page_acc = 4'd1; cfg_gran_x2 = 1'b1;
        run(1'b1, 4'd2, 16'hAAAA, 16'h5555, 32'd0, 6);
        chk("R5", "burst write edges (spacing 1x2)", mcap_m, b(2) | b(4));
        chk("R5", "first word data", {dqo[1], dqo[2]}, 32'hAAAAAAAA);
        chk("R5", "second word data", {dqo[3], dqo[4]}, 32'h55555555);
        chk("R8", "ready after burst write", rdy_m, span(5, 6));
        cfg_gran_x2 = 1'b0;
    endtask

    task automatic t_read_single;
        cfg_sync = 1'b1; cfg_rd_acc = 5'd3; cfg_rd_cyc = 5'd5;
        run(1'b0, 4'd1, 16'h0, 16'h0, 32'd0, 8);
        chk("R2", "read capture cycle", cap_m, b(3));
        chk("R2", "done cycle", done_m, b(4));
        chk("R2", "read data", {16'd0, rdv[4]}, 32'h00001003);
        chk("R8", "ready after read", rdy_m, span(6, 8));
        chk("R9", "bus released then kept", dqoe_m, span(6, 8));
        chk("R9", "kept read word", {16'd0, dqo[8]}, 32'h00001003);
        chk("R2", "output enable", oe_m, span(1, 3));
    endtask

    task automatic t_read_wait;
        run(1'b0, 4'd1, 16'h0, 16'h0, b(3) | b(4), 10);
        chk("R4", "read capture with wait", cap_m, b(5));
        chk("R4", "read data with wait", {16'd0, rdv[6]}, 32'h00001005);
        chk("R8", "ready with read wait", rdy_m, span(8, 10));
    endtask

    task automatic t_read_burst;
        cfg_rd_acc = 5'd2; cfg_rd_cyc = 5'd4; cfg_page_acc = 4'd2; cfg_gran_x2 = 1'b1;
        run(1'b0, 4'd3, 16'h0, 16'h0, 32'd0, 12);
        chk("R3", "page capture spacing 2x2", cap_m, b(2) | b(6) | b(10));
        chk("R3", "page done pulses", done_m, b(3) | b(7) | b(11));
        chk("R3", "page words", {rdv[3], rdv[7]}, 32'h10021006);
        chk("R3", "last page word", {16'd0, rdv[11]}, 32'h0000100A);
        chk("R8", "ready after page", rdy_m, span(11, 12));
        cfg_page_acc = 4'd4; cfg_gran_x2 = 1'b0;
        run(1'b0, 4'd2, 16'h0, 16'h0, b(4), 9);
        chk("R4", "wait on later page word", cap_m, b(2) | b(7));
        chk("R8", "ready after waited page", rdy_m, span(8, 9));
    endtask

    task automatic t_async_write;
        cfg_sync = 1'b0; cfg_wr_acc = 5'd5; cfg_wr_cyc = 5'd7;
        run(1'b1, 4'd1, 16'h7777, 16'h7777, b(2) | b(3), 9);
        chk("R6", "early wait ignored", we_m, span(1, 5));
        chk("R6", "no capture edge", mcap_m, 32'd0);
        chk("R8", "ready async write", rdy_m, span(8, 9));
        run(1'b1, 4'd1, 16'h6666, 16'h6666, b(4), 10);
        chk("R6", "late wait obeyed", we_m, span(1, 6));
        chk("R8", "ready async waited", rdy_m, span(9, 10));
    endtask

    task automatic t_async_reject;
        run(1'b1, 4'd2, 16'h0123, 16'h0123, 32'd0, 3);
        chk("R7", "reject done/err", done_m & err_m, b(1));
        chk("R7", "no strobe", we_m, 32'd0);
        chk("R7", "ready stays", rdy_m, span(1, 3));
        chk("R7", "bus word unchanged", {16'd0, dqo[3]}, 32'h00006666);
    endtask

    task automatic t_bad_cfg;
        @(negedge clk);
        cfg_rd_acc = 5'd3; cfg_rd_cyc = 5'd3;
        #1 chk("R1", "flag equal counts", {31'd0, cfg_err}, 32'd1);
        run(1'b0, 4'd1, 16'h0, 16'h0, 32'd0, 3);
        chk("R1", "read rejected", done_m & err_m, b(1));
        chk("R1", "no read strobe", oe_m | cap_m, 32'd0);
        cfg_rd_cyc = 5'd4;
        #1 chk("R1", "flag clear when cycle > access", {31'd0, cfg_err}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sync_write();
        t_sync_wait();
        t_sync_burst();
        t_read_single();
        t_read_wait();
        t_read_burst();
        t_async_write();
        t_async_reject();
        t_bad_cfg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule